// File: doc/BRIEF.md
# West-First Adaptive Route Selector

This block computes the output direction for one packet at one router of a two-dimensional mesh. It uses the west-first turn model. The inputs are the packet's signed remaining X and Y offsets, plus a busy flag and a failed flag for each of the four neighbour links. The output is a one-hot choice among local, west, east, north and south. When no usable minimal link exists, the output is a flag that marks the packet as unroutable.

Westward travel is always done first, and it is deterministic: while any westward offset remains, west is the only direction considered. After that, the selector picks among the productive east, north and south links. It steers away from links that are busy or have failed, so the route always stays minimal. The logic is purely combinational. The result depends only on the offsets and flags present in the same cycle, so a router can use it inside its route-compute stage.

Top module: `wf_route_sel`

## Requirements
- R1: With both offsets zero, `port_sel` is 5'b00001 (bit 0 = local) and `unroutable` is low, whatever the flags are.
- R2: With a negative X offset and the west link not failed, `port_sel` is 5'b00010 (bit 1 = west), whatever the Y offset or the busy flags are.
- R3: With a negative X offset and the west link failed (flag bit 0), `unroutable` is high and `port_sel` is zero, even if a Y link is free.
- R4: With a zero X offset and a nonzero Y offset, the only candidate is north (`port_sel` bit 3) for a positive Y offset, or south (bit 4) for a negative one.
- R5: With a positive X offset and a zero Y offset, east (`port_sel` bit 2) is chosen, even when east is busy.
- R6: With a positive X offset, a nonzero Y offset, and both candidates either free or both busy, east is chosen.
- R7: With a positive X offset, a nonzero Y offset, and exactly one of the two candidates busy, the non-busy candidate is chosen.
- R8: When one of two productive candidates is failed, the other is chosen regardless of its busy flag.
- R9: When every productive link is failed, `unroutable` is high and `port_sel` is zero.
- R10: Busy and failed flags of non-productive directions do not change the selection.
- R11: `port_sel` has exactly one bit set when `unroutable` is low, and is zero when it is high.
- R12: The extreme offset values (most negative, most positive) are decoded with the correct sign.

Flag bit order (both `link_busy` and `link_failed`): bit 0 west, bit 1 east, bit 2 north, bit 3 south. Positive Y means north.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dx | input | OFS_W | Signed remaining X offset; positive means east |
| dy | input | OFS_W | Signed remaining Y offset; positive means north |
| link_busy | input | 4 | Congestion flag per neighbour link (W,E,N,S = bits 0..3) |
| link_failed | input | 4 | Fault flag per neighbour link (W,E,N,S = bits 0..3) |
| port_sel | output | 5 | One-hot choice: local, west, east, north, south = bits 0..4 |
| unroutable | output | 1 | High when no productive link is usable |

## Verification
The bench builds the selector with the default 8-bit offsets. This puts the extreme values -128 and 127 within reach, so the sign decoding at the range limits is tested directly. It covers every offset-sign quadrant, together with busy and fail patterns that separate the tie-break rule, the congestion preference, fault avoidance and the ignored flags of non-productive links.

// File: rtl/wf_route_pkg.sv
package wf_route_pkg;
    localparam int NLINK = 4;
    localparam int NSEL  = NLINK + 1;
    // link indices (flag vectors)
    localparam int LK_W = 0;
    localparam int LK_E = 1;
    localparam int LK_N = 2;
    localparam int LK_S = 3;
    // output selection bit for local delivery; link i maps to bit i+1
    localparam int SEL_LOCAL = 0;
    localparam logic [NLINK-1:0] X_LINKS = 4'b0011;
    localparam logic [NLINK-1:0] Y_LINKS = 4'b1100;
endpackage

// File: rtl/wf_productive.sv
module wf_productive
    import wf_route_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic signed [OFS_W-1:0] dx_i,
    input  logic signed [OFS_W-1:0] dy_i,
    output logic                    at_dest_o,
    output logic [NLINK-1:0]        prod_o
);
    logic west_phase;

    always_comb begin
        west_phase   = (dx_i < 0);
        at_dest_o    = (dx_i == 0) && (dy_i == 0);
        prod_o       = '0;
        prod_o[LK_W] = west_phase;
        prod_o[LK_E] = (dx_i > 0);
        // Y travel only once westward movement is finished
        prod_o[LK_N] = !west_phase && (dy_i > 0);
        prod_o[LK_S] = !west_phase && (dy_i < 0);
    end
endmodule

// File: rtl/wf_pick.sv
module wf_pick
    import wf_route_pkg::*;
(
    input  logic [NLINK-1:0] prod_i,
    input  logic [NLINK-1:0] busy_i,
    input  logic [NLINK-1:0] fail_i,
    output logic [NLINK-1:0] grant_o,
    output logic             blocked_o
);
    logic [NLINK-1:0] usable;
    logic [NLINK-1:0] free;
    logic [NLINK-1:0] x_mask;
    logic [NLINK-1:0] y_mask;
    logic             x_free;
    logic             y_free;

    for (genvar i = 0; i < NLINK; i++) begin : g_link
        assign usable[i] = prod_i[i] & ~fail_i[i];
        assign free[i]   = usable[i] & ~busy_i[i];
    end

    always_comb begin
        x_mask    = usable & X_LINKS;
        y_mask    = usable & Y_LINKS;
        x_free    = |(free & X_LINKS);
        y_free    = |(free & Y_LINKS);
        grant_o   = '0;
        blocked_o = 1'b0;
        if (x_mask == '0 && y_mask == '0) begin
            blocked_o = |prod_i;
        end else if (y_mask == '0) begin
            grant_o = x_mask;
        end else if (x_mask == '0) begin
            grant_o = y_mask;
        end else if (x_free == y_free) begin
            grant_o = x_mask;          // tie: prefer the X dimension
        end else begin
            grant_o = x_free ? x_mask : y_mask;
        end
    end
endmodule

// File: rtl/wf_route_sel.sv
module wf_route_sel
    import wf_route_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic signed [OFS_W-1:0] dx,
    input  logic signed [OFS_W-1:0] dy,
    input  logic [3:0]              link_busy,
    input  logic [3:0]              link_failed,
    output logic [4:0]              port_sel,
    output logic                    unroutable
);
    logic             at_dest;
    logic [NLINK-1:0] prod;
    logic [NLINK-1:0] grant;
    logic             blocked;

    wf_productive #(.OFS_W(OFS_W)) u_prod (
        .dx_i      (dx),
        .dy_i      (dy),
        .at_dest_o (at_dest),
        .prod_o    (prod)
    );

    wf_pick u_pick (
        .prod_i    (prod),
        .busy_i    (link_busy),
        .fail_i    (link_failed),
        .grant_o   (grant),
        .blocked_o (blocked)
    );

    always_comb begin
        port_sel   = '0;
        unroutable = 1'b0;
        if (at_dest) begin
            port_sel[SEL_LOCAL] = 1'b1;
        end else begin
            port_sel[NSEL-1:1] = grant;
            unroutable         = blocked;
        end
    end

    always_comb begin
        a_r11_onehot: assert (unroutable ? (port_sel == '0) : $onehot(port_sel))
            else $error("R11 selection not one-hot");
        if (dx == 0 && dy == 0)
            a_r1_local: assert (port_sel == 5'b00001 && !unroutable)
                else $error("R1 local delivery");
        if (dx < 0 && !unroutable)
            a_r2_west_first: assert (port_sel == 5'b00010)
                else $error("R2 west first");
        if (!unroutable && port_sel != '0)
            a_r9_no_failed_pick: assert ((port_sel[4:1] & link_failed) == '0)
                else $error("R9 failed link chosen");
        if (dx >= 0)
            a_r4_no_west_later: assert (port_sel[1] == 1'b0)
                else $error("R4 west turn after leaving west phase");
    end
endmodule

// File: tb/sim_wf_route_sel.sv
module sim_wf_route_sel;
    typedef struct {
        logic [4:0] sel;
        logic       unr;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [7:0] dx = '0;
    logic signed [7:0] dy = '0;
    logic [3:0] busy = '0;
    logic [3:0] fail = '0;
    logic [4:0] port_sel;
    logic unroutable;
    exp_t sb[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wf_route_sel #(.OFS_W(8)) u0 (
        .dx(dx), .dy(dy), .link_busy(busy), .link_failed(fail),
        .port_sel(port_sel), .unroutable(unroutable)
    );

    task automatic drive(input int x, input int y, input logic [3:0] b,
                         input logic [3:0] f, input logic [4:0] es,
                         input logic eu, input string tag);
        exp_t e;
        @(posedge clk);
        dx = 8'(x); dy = 8'(y); busy = b; fail = f;
        e.sel = es; e.unr = eu; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (port_sel !== e.sel || unroutable !== e.unr) begin
                n_fail++;
                $display("FAIL %s: sel=%b unr=%b expected sel=%b unr=%b",
                         e.tag, port_sel, unroutable, e.sel, e.unr);
            end
            n_run++;
            if (unroutable ? (port_sel != 0) : ($countones(port_sel) != 1)) begin
                n_fail++;
                $display("FAIL R11 (%s): sel=%b unr=%b expected one-hot or zero",
                         e.tag, port_sel, unroutable);
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // reset state: offsets zero -> local
        drive(0, 0, 4'h0, 4'h0, 5'b00001, 0, "R1 idle");
        drive(0, 0, 4'hF, 4'hF, 5'b00001, 0, "R1 all flags");
        drive(-3, 2, 4'b0001, 4'h0, 5'b00010, 0, "R2 west busy");
        drive(-1, -5, 4'b1110, 4'b0000, 5'b00010, 0, "R2 west dy neg");
        drive(-1, -5, 4'h0, 4'b0001, 5'b00000, 1, "R3 west failed");
        drive(0, 4, 4'h0, 4'h0, 5'b01000, 0, "R4 north");
        drive(0, -2, 4'h0, 4'h0, 5'b10000, 0, "R4 south");
        drive(5, 0, 4'b0010, 4'h0, 5'b00100, 0, "R5 east busy");
        drive(2, 3, 4'h0, 4'h0, 5'b00100, 0, "R6 both free");
        drive(2, 3, 4'b0110, 4'h0, 5'b00100, 0, "R6 both busy");
        drive(2, 3, 4'b0010, 4'h0, 5'b01000, 0, "R7 east busy");
        drive(2, -3, 4'b1000, 4'h0, 5'b00100, 0, "R7 south busy");
        drive(2, -1, 4'b0010, 4'h0, 5'b10000, 0, "R7 east busy south");
        drive(2, 3, 4'b0100, 4'b0010, 5'b01000, 0, "R8 east failed");
        drive(2, 3, 4'b0010, 4'b0100, 5'b00100, 0, "R8 north failed");
        drive(1, 1, 4'h0, 4'b0110, 5'b00000, 1, "R9 both failed");
        drive(0, -1, 4'h0, 4'b1000, 5'b00000, 1, "R9 south failed");
        drive(4, 0, 4'h0, 4'b0010, 5'b00000, 1, "R9 east failed");
        drive(3, 0, 4'b1101, 4'b1101, 5'b00100, 0, "R10 off-path flags");
        drive(0, 6, 4'b1011, 4'b1011, 5'b01000, 0, "R10 north only");
        drive(-2, 3, 4'h0, 4'b1100, 5'b00010, 0, "R10 y flags in west phase");
        drive(-128, 127, 4'h0, 4'h0, 5'b00010, 0, "R12 min dx");
        drive(127, -128, 4'b0010, 4'h0, 5'b10000, 0, "R12 max dx");
        drive(0, -128, 4'h0, 4'h0, 5'b10000, 0, "R12 min dy");
        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule